// File: doc/BRIEF.md
# Bulk Endpoint DMA Termination Controller

This block runs the slave side of a DMA transfer between a 16-bit external data bus and the FIFO of one bulk USB endpoint. It raises a request to an external DMA controller, qualifies each acknowledged data beat, and counts beats against a programmed length. It then decides when the transfer is over and what happens to the endpoint buffer as a result.

A transfer ends on the first of four causes: the external end-of-transfer line, the beat counter running out while counting is enabled, a short packet on an OUT endpoint while that cause is enabled, or software dropping the enable. An OUT transfer ended by the external line discards the contents of the active buffer. The other buffer of a double-buffered endpoint is left as it is. Any end of an IN transfer hands the bytes already written to the USB side as a finished packet, even if that packet is short. A separate strobe mode lets the acknowledge line alone act as the data strobe.

Top module: `dma_eot_ctrl`

## Requirements
- R1: `dreq` rises in the cycle after `dma_en` is seen high while idle. It falls in the cycle after any termination cause is detected, and stays low until `dma_en` has been low and is raised again.
- R2: `ext_eot` passes through a two-flop synchronizer, so a termination it causes shows on `done` three clock edges after the input is applied. It is ignored while no transfer is active.
- R3: A beat decrements the loaded `xfer_count`. With `cnt_en`=1, the beat taken while the remaining count is 1 or 0 ends the transfer, so a count of 0 ends on the first beat. With `cnt_en`=0 the count never ends a transfer.
- R4: `short_pkt` ends a transfer only when `short_en`=1 and the transfer direction is OUT (`dir_in`=0). In any other case it has no effect.
- R5: Clearing `dma_en` during an active transfer ends it.
- R6: An OUT transfer ended by the external end-of-transfer gives a one-cycle `flush` pulse, with `evt_buf` naming the active buffer. The flush does not change `buf_sel`. No other cause flushes.
- R7: Any termination of an IN transfer gives a one-cycle `commit` pulse, with `evt_buf` naming the active buffer. With `dbuf_en`=1, `buf_sel` toggles one cycle after the commit.
- R8: With `ack_only`=1, `beat` equals `dack` during a transfer, and `rd_strobe`/`wr_strobe` are ignored. With `ack_only`=0, a beat needs `dack` together with `rd_strobe` for OUT or `wr_strobe` for IN.
- R9: `cause` is a sticky vector: bit 0 external end-of-transfer, bit 1 counter, bit 2 short packet, bit 3 enable cleared. Causes that fire in the same cycle are all recorded, with exactly one `done` pulse. `cause` clears when the next transfer starts.
- R10: With `dbuf_en`=1, a `pkt_full` pulse toggles `buf_sel`. With `dbuf_en`=0, `buf_sel` is held at 0.
- R11: During reset, `dreq`, `beat`, `done`, `flush`, `commit`, `evt_buf`, `buf_sel` and `cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | Software DMA enable |
| dir_in | input | 1 | 1 = IN endpoint (bus writes FIFO), 0 = OUT endpoint (bus reads FIFO) |
| cnt_en | input | 1 | Enable counter termination |
| short_en | input | 1 | Enable short-packet termination |
| ack_only | input | 1 | Acknowledge line acts as data strobe |
| dbuf_en | input | 1 | Endpoint is double-buffered |
| xfer_count | input | CNT_W | Programmed number of beats |
| dack | input | 1 | DMA acknowledge |
| rd_strobe | input | 1 | Read strobe |
| wr_strobe | input | 1 | Write strobe |
| ext_eot | input | 1 | Asynchronous external end-of-transfer |
| short_pkt | input | 1 | Short packet received (pulse from USB side) |
| pkt_full | input | 1 | Active buffer filled (pulse from FIFO side) |
| dreq | output | 1 | DMA request |
| beat | output | 1 | Qualified data beat this cycle |
| done | output | 1 | One-cycle transfer completion pulse |
| flush | output | 1 | Discard active buffer |
| commit | output | 1 | Mark active buffer as a complete packet |
| evt_buf | output | 1 | Buffer index that the flush or commit applies to |
| buf_sel | output | 1 | Active buffer index |
| cause | output | 4 | Sticky termination causes |

## Verification
A wrong internal state shows at the ports within one or two cycles. A stuck or early transition of the transfer state makes `dreq` stay high or fall too soon, and beats outside a transfer appear on `beat`. A counter that is off by one changes the number of beats before `done`. A wrong direction latch sends `flush` in place of `commit`, or the reverse. A toggle that fires on a flush shows as a changed `buf_sel` one cycle later. The synchronizer depth is checked by the exact edge on which `done` follows `ext_eot`.

// File: rtl/dma_eot_pkg.sv
package dma_eot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DONE   = 2'd2
  } xfer_state_t;

  localparam int CAUSE_W     = 4;
  localparam int CAUSE_EOT   = 0;
  localparam int CAUSE_CNT   = 1;
  localparam int CAUSE_SHORT = 2;
  localparam int CAUSE_DIS   = 3;
endpackage

// File: rtl/dma_beat_qual.sv
module dma_beat_qual (
  input  logic active,
  input  logic ack_only,
  input  logic xfer_in,
  input  logic dack,
  input  logic rd_strobe,
  input  logic wr_strobe,
  output logic beat
);
  logic strobe_ok;

  always_comb begin
    if (ack_only) strobe_ok = 1'b1;
    else          strobe_ok = xfer_in ? wr_strobe : rd_strobe;
    beat = active & dack & strobe_ok;
  end
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q, rem_d;
  logic             rem_ce;

  always_comb begin
    rem_ce = load | (dec & (rem_q != '0));
    rem_d  = load ? load_val : (rem_q - ONE);
    last   = (rem_q[CNT_W-1:1] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_ce) rem_q <= rem_d;
  end

  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dec) |=> $stable(rem_q));
endmodule

// File: rtl/dma_end_detect.sv
module dma_end_detect
  import dma_eot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               xfer_in,
  input  logic               dma_en,
  input  logic               cnt_hit,
  input  logic               short_en,
  input  logic               short_pkt,
  input  logic               ext_eot,
  output logic [CAUSE_W-1:0] cause_vec,
  output logic               term
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      assign sync_d[g] = ext_eot;
    end else begin : g_next
      assign sync_d[g] = sync_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  always_comb begin
    cause_vec              = '0;
    cause_vec[CAUSE_EOT]   = active & sync_q[SYNC_STAGES-1];
    cause_vec[CAUSE_CNT]   = active & cnt_hit;
    cause_vec[CAUSE_SHORT] = active & short_en & short_pkt & ~xfer_in;
    cause_vec[CAUSE_DIS]   = active & ~dma_en;
    term                   = |cause_vec;
  end

  assert_term_only_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !term);
endmodule

// File: rtl/dma_eot_ctrl.sv
module dma_eot_ctrl
  import dma_eot_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dma_en,
  input  logic               dir_in,
  input  logic               cnt_en,
  input  logic               short_en,
  input  logic               ack_only,
  input  logic               dbuf_en,
  input  logic [CNT_W-1:0]   xfer_count,
  input  logic               dack,
  input  logic               rd_strobe,
  input  logic               wr_strobe,
  input  logic               ext_eot,
  input  logic               short_pkt,
  input  logic               pkt_full,
  output logic               dreq,
  output logic               beat,
  output logic               done,
  output logic               flush,
  output logic               commit,
  output logic               evt_buf,
  output logic               buf_sel,
  output logic [CAUSE_W-1:0] cause
);
  xfer_state_t        state_q, state_d;
  logic               dir_q, dir_d;
  logic [CAUSE_W-1:0] cause_q, cause_d, cause_vec;
  logic               done_q, flush_q, commit_q, evt_q, buf_q;
  logic               done_d, flush_d, commit_d, evt_d, buf_d;
  logic               start, active, term, last, cnt_hit, buf_ce, cause_ce;

  assign active  = (state_q == ST_ACTIVE);
  assign start   = (state_q == ST_IDLE) & dma_en;
  assign cnt_hit = cnt_en & beat & last;

  dma_beat_qual u_qual (
    .active    (active),
    .ack_only  (ack_only),
    .xfer_in   (dir_q),
    .dack      (dack),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .beat      (beat)
  );

  dma_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (xfer_count),
    .dec      (beat),
    .last     (last)
  );

  dma_end_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .xfer_in   (dir_q),
    .dma_en    (dma_en),
    .cnt_hit   (cnt_hit),
    .short_en  (short_en),
    .short_pkt (short_pkt),
    .ext_eot   (ext_eot),
    .cause_vec (cause_vec),
    .term      (term)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (dma_en) state_d = ST_ACTIVE;
      ST_ACTIVE: if (term)   state_d = ST_DONE;
      ST_DONE:   if (!dma_en) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    dir_d    = start ? dir_in : dir_q;
    cause_ce = start | term;
    cause_d  = start ? '0 : (cause_q | cause_vec);
    done_d   = term;
    flush_d  = term & ~dir_q & cause_vec[CAUSE_EOT];
    commit_d = term & dir_q;
    evt_d    = term ? buf_q : 1'b0;
    buf_ce   = ~dbuf_en | commit_q | pkt_full;
    buf_d    = dbuf_en ? ~buf_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dir_q    <= 1'b0;
      cause_q  <= '0;
      done_q   <= 1'b0;
      flush_q  <= 1'b0;
      commit_q <= 1'b0;
      evt_q    <= 1'b0;
      buf_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      dir_q    <= dir_d;
      done_q   <= done_d;
      flush_q  <= flush_d;
      commit_q <= commit_d;
      evt_q    <= evt_d;
      if (cause_ce) cause_q <= cause_d;
      if (buf_ce)   buf_q   <= buf_d;
    end
  end

  assign dreq    = active;
  assign done    = done_q;
  assign flush   = flush_q;
  assign commit  = commit_q;
  assign evt_buf = evt_q;
  assign buf_sel = buf_q;
  assign cause   = cause_q;

  assert_dreq_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> !dreq);
  assert_dreq_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq) |-> $past(dma_en));
  assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cause != '0));
  assert_flush_not_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !commit);
  assert_flush_keeps_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !pkt_full && dbuf_en) |=> $stable(buf_sel));
  assert_buf_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(buf_sel) |-> $past(commit | pkt_full | !dbuf_en));
  assert_beat_in_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (dreq && dack));
endmodule

// File: tb/test_dma_eot_ctrl.sv
module test_dma_eot_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int NVEC       = 7;

  typedef struct packed {
    logic       dir;
    logic       ack;
    logic       rd;
    logic       wr;
    logic       cen;
    logic [7:0] cnt;
    logic [3:0] nb;
    logic [3:0] ecause;
    logic [3:0] ebeats;
    logic       ecommit;
  } vec_t;

  // dir ack rd wr cen cnt nb cause beats commit
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd3, 4'd5, 4'b0010, 4'd3, 1'b0}, // R3 OUT count
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd2, 4'd4, 4'b1000, 4'd0, 1'b0}, // R8 wrong strobe, R5
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd2, 4'd3, 4'b0010, 4'd2, 1'b0}, // R8 ack only
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 4'd4, 4'b1000, 4'd4, 1'b1}, // R3 no count, R7
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd4, 4'd4, 4'b0010, 4'd4, 1'b1}, // R3 exact, R7
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd1, 4'd2, 4'b0010, 4'd1, 1'b1}, // R8 strobes ignored
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 4'd2, 4'b0010, 4'd1, 1'b0}  // R3 zero count
  };

  logic clk, rst_n;
  logic dma_en, dir_in, cnt_en, short_en, ack_only, dbuf_en;
  logic [CNT_W-1:0] xfer_count;
  logic dack, rd_strobe, wr_strobe, ext_eot, short_pkt, pkt_full;
  logic dreq, beat, done, flush, commit, evt_buf, buf_sel;
  logic [3:0] cause;

  int checks, fails;
  int n_beat, n_done, n_flush, n_commit;
  bit finished;

  dma_eot_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_dma_eot_ctrl (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dir_in(dir_in), .cnt_en(cnt_en),
    .short_en(short_en), .ack_only(ack_only), .dbuf_en(dbuf_en),
    .xfer_count(xfer_count), .dack(dack), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .ext_eot(ext_eot), .short_pkt(short_pkt),
    .pkt_full(pkt_full), .dreq(dreq), .beat(beat), .done(done), .flush(flush),
    .commit(commit), .evt_buf(evt_buf), .buf_sel(buf_sel), .cause(cause)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_beat = 0; n_done = 0; n_flush = 0; n_commit = 0;
  endtask

  task automatic step();
    #1;
    if (beat) n_beat++;
    @(negedge clk);
    if (done)   n_done++;
    if (flush)  n_flush++;
    if (commit) n_commit++;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; finished = 0;
    clr_mon();
    rst_n = 1'b0; dma_en = 0; dir_in = 0; cnt_en = 0; short_en = 0; ack_only = 0;
    dbuf_en = 0; xfer_count = '0; dack = 0; rd_strobe = 0; wr_strobe = 0;
    ext_eot = 0; short_pkt = 0; pkt_full = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 dreq", dreq, 0);
    chk("R11 done/flush/commit", {done, flush, commit}, 0);
    chk("R11 buf_sel/evt_buf", {buf_sel, evt_buf}, 0);
    chk("R11 cause", cause, 0);
    rst_n = 1'b1;
    step();

    // R10 single-buffered: pkt_full leaves buf_sel at 0
    pkt_full = 1; step(); pkt_full = 0; step();
    chk("R10 buf_sel single", buf_sel, 0);

    // R2 external end-of-transfer while idle is ignored
    clr_mon();
    ext_eot = 1; step(); ext_eot = 0; step(); step(); step();
    chk("R2 idle eot done", n_done, 0);
    chk("R2 idle eot cause", cause, 0);

    // R10 double-buffered toggle on pkt_full
    dbuf_en = 1; pkt_full = 1; step(); pkt_full = 0;
    chk("R10 buf_sel toggled", buf_sel, 1);

    // R6 / R2 / R1 OUT transfer ended by external EOT
    dir_in = 0; dma_en = 1; step();
    chk("R1 dreq up", dreq, 1);
    ext_eot = 1; step(); ext_eot = 0; step();
    chk("R2 dreq before sync", dreq, 1);
    step();
    chk("R6 flush", flush, 1);
    chk("R6 evt_buf", evt_buf, 1);
    chk("R2 done after sync", done, 1);
    chk("R1 dreq down", dreq, 0);
    step();
    chk("R6 flush pulse", flush, 0);
    chk("R6 buf_sel kept", buf_sel, 1);
    chk("R9 cause eot", cause, 4'b0001);
    dma_en = 0; step();

    // R4 short packet on OUT with enable
    short_en = 1; dma_en = 1; step();
    short_pkt = 1; step(); short_pkt = 0;
    chk("R4 short done", done, 1);
    chk("R4 short cause", cause, 4'b0100);
    chk("R6 no flush on short", flush, 0);
    step(); step();
    chk("R1 dreq stays low", dreq, 0);
    dma_en = 0; step();

    // R4 short packet ignored with enable off
    short_en = 0; dma_en = 1; step();
    short_pkt = 1; step(); short_pkt = 0; step();
    chk("R4 short disabled", dreq, 1);
    chk("R4 short disabled cause", cause, 0);
    dma_en = 0; step(); step();
    chk("R5 disable cause", cause, 4'b1000);

    // R4 short packet ignored on IN
    short_en = 1; dir_in = 1; dma_en = 1; step();
    short_pkt = 1; step(); short_pkt = 0;
    chk("R4 short on IN", dreq, 1);
    dma_en = 0; step(); step();
    chk("R7 buf_sel after IN commit", buf_sel, 0);

    // R7 IN commit on counter, toggle a cycle later
    short_en = 0; cnt_en = 1; xfer_count = 16'd1; dma_en = 1; step();
    dack = 1; wr_strobe = 1; step(); dack = 0; wr_strobe = 0;
    chk("R7 commit", commit, 1);
    chk("R7 evt_buf", evt_buf, 0);
    chk("R7 buf_sel not yet", buf_sel, 0);
    step();
    chk("R7 buf_sel toggled", buf_sel, 1);
    chk("R7 commit pulse", commit, 0);
    dma_en = 0; step();

    // R9 simultaneous counter and short packet
    clr_mon();
    dir_in = 0; short_en = 1; xfer_count = 16'd1; dma_en = 1; step();
    dack = 1; rd_strobe = 1; short_pkt = 1; step();
    dack = 0; rd_strobe = 0; short_pkt = 0;
    chk("R9 both causes", cause, 4'b0110);
    step();
    chk("R9 one done", n_done, 1);
    dma_en = 0; step();

    // table of transfers: R3 R5 R7 R8
    dbuf_en = 0; short_en = 0;
    for (int v = 0; v < NVEC; v++) begin
      clr_mon();
      dir_in = VECS[v].dir; ack_only = VECS[v].ack; cnt_en = VECS[v].cen;
      xfer_count = {8'h00, VECS[v].cnt};
      dma_en = 1; step();
      for (int k = 0; k < int'(VECS[v].nb); k++) begin
        dack = 1; rd_strobe = VECS[v].rd; wr_strobe = VECS[v].wr;
        step();
      end
      dack = 0; rd_strobe = 0; wr_strobe = 0; dma_en = 0;
      step(); step();
      chk($sformatf("R3/R8 beats vec%0d", v), n_beat, int'(VECS[v].ebeats));
      chk($sformatf("R9/R5 cause vec%0d", v), cause, int'(VECS[v].ecause));
      chk($sformatf("R7 commits vec%0d", v), n_commit, int'(VECS[v].ecommit));
      chk($sformatf("R9 done vec%0d", v), n_done, 1);
      chk($sformatf("R6 no flush vec%0d", v), n_flush, 0);
      chk($sformatf("R10 buf_sel vec%0d", v), buf_sel, 0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule